// File: doc/BRIEF.md
# Indexed Register Window Bridge

This block sits on the slave side of a host bus and gives a host with a narrow address window access to a controller's 28-bit internal command/data address space. The host sees two 32-bit registers. Writing the control register stores an internal address. Reading or writing the data register then runs a single access on an internal request/response port at that stored address.

The stored address is also split into fields and driven on separate outputs, so the logic behind the bridge does not have to decode it again. The fields are a two-bit access-map selector, a two-bit bank number and the low command/page field. When the raw device-cycle map is selected, the bridge also reports the kind of device cycle. Host accesses use a simple select/ready handshake. Reads of the data register stall until the internal side returns data.

Top module: `ixb_bridge`

## Requirements
- R1: A host write at byte offset 0x00 (control) stores bits 27:0 of the write data as the internal address and ignores bits 31:28. A host read at 0x00 returns the stored address with bits 31:28 zero, and host_ready rises on the first cycle after the access is accepted.
- R2: The stored address is unchanged by any access at offset 0x10 (data) and keeps its value until the next control write.
- R3: A host write at offset 0x10 raises exactly one internal request with int_we=1, int_addr equal to the stored address and int_wdata equal to the host data. host_ready rises one cycle after the cycle in which int_ack is seen.
- R4: A host read at offset 0x10 raises one internal request with int_we=0 at the stored address. host_ready stays low until int_rvalid has been seen, and host_rdata then equals the int_rdata captured with int_rvalid.
- R5: While int_req is high and int_ack is low, int_req, int_we, int_addr and int_wdata hold their values on the next cycle.
- R6: A host access at any offset other than 0x00 or 0x10 raises no internal request and leaves the stored address unchanged. A read there returns zero, and host_ready rises one cycle after acceptance.
- R7: map_sel equals bits 27:26 of the stored address. The encodings are 0 direct buffer, 1 paged PIO, 2 command plane and 3 raw device cycles.
- R8: bank equals bits 25:24 of the stored address (bank 0 to 3).
- R9: low_field equals bits 23:0 of the stored address. cyc_vld is high only when map_sel is 3 and bits 1:0 are not 3. In that case cyc_kind equals bits 1:0 (0 command, 1 address, 2 data); otherwise cyc_kind reads 3.
- R10: After reset the stored address is zero, int_req is low and host_ready is low.
- R11: host_ready is high for exactly one cycle per host access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request, held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_ready |
| host_ready | output | 1 | Access complete (one-cycle pulse) |
| int_req | output | 1 | Internal request |
| int_we | output | 1 | Internal request is a write |
| int_addr | output | 28 | Internal address (stored address) |
| int_wdata | output | 32 | Internal write data |
| int_ack | input | 1 | Internal port accepts the request |
| int_rvalid | input | 1 | Internal read data valid |
| int_rdata | input | 32 | Internal read data |
| map_sel | output | 2 | Access-map selector field |
| bank | output | 2 | Bank field |
| low_field | output | 24 | Low command/page field |
| cyc_kind | output | 2 | Raw device-cycle kind, 3 when none |
| cyc_vld | output | 1 | cyc_kind is meaningful |

## Verification
The assertions assume three things about the inputs:
- The host keeps host_sel and its access fields steady until host_ready and drops host_sel in the cycle where host_ready is seen.
- The internal side raises int_ack only while int_req is high.
- The internal side raises int_rvalid only after the cycle that accepted a read.

The bench host tasks lower host_sel at the same falling edge where they observe host_ready. The bench responder acknowledges only pending requests and returns read data one or more cycles after the acknowledge. Acknowledge and read delays are varied across the scenarios so that the stall and hold behaviour is exercised.

// File: rtl/ixb_pkg.sv
package ixb_pkg;

    // Access-map selector values (field decoded by downstream logic)
    typedef enum logic [1:0] {
        MAP_BUF   = 2'd0,
        MAP_PIO   = 2'd1,
        MAP_PLANE = 2'd2,
        MAP_RAW   = 2'd3
    } map_e;

    // Raw device-cycle kinds
    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ADR  = 2'd1,
        CYC_DAT  = 2'd2,
        CYC_NONE = 2'd3
    } cyc_e;

    // Host register hit classification
    typedef enum logic [1:0] {
        HIT_CTRL  = 2'd0,
        HIT_DATA  = 2'd1,
        HIT_OTHER = 2'd2
    } hit_e;

    // Access sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WPUT  = 3'd1,
        ST_RGET  = 3'd2,
        ST_RWAIT = 3'd3,
        ST_RESP  = 3'd4
    } seq_e;

    function automatic hit_e classify(input logic is_ctrl, input logic is_data);
        if (is_ctrl)      return HIT_CTRL;
        else if (is_data) return HIT_DATA;
        else              return HIT_OTHER;
    endfunction

endpackage

// File: rtl/ixb_addr_latch.sv
module ixb_addr_latch #(
    parameter int IADDR_W = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wen,
    input  logic [IADDR_W-1:0] wval,
    output logic [IADDR_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (wen) q <= wval;
    end

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wen |=> $stable(q));

endmodule

// File: rtl/ixb_field_split.sv
module ixb_field_split
    import ixb_pkg::*;
#(
    parameter int IADDR_W = 28
) (
    input  logic [IADDR_W-1:0] addr,
    output logic [1:0]         map_sel,
    output logic [1:0]         bank,
    output logic [IADDR_W-5:0] low_field,
    output logic [1:0]         cyc_kind,
    output logic               cyc_vld
);

    localparam int MAP_LO  = IADDR_W - 2;
    localparam int BANK_LO = IADDR_W - 4;

    map_e map_v;
    cyc_e cyc_v;

    always_comb begin
        map_v     = map_e'(addr[MAP_LO +: 2]);
        bank      = addr[BANK_LO +: 2];
        low_field = addr[BANK_LO-1:0];
        if (map_v == MAP_RAW && cyc_e'(addr[1:0]) != CYC_NONE) begin
            cyc_v   = cyc_e'(addr[1:0]);
            cyc_vld = 1'b1;
        end else begin
            cyc_v   = CYC_NONE;
            cyc_vld = 1'b0;
        end
        map_sel  = map_v;
        cyc_kind = cyc_v;
    end

endmodule

// File: rtl/ixb_access_seq.sv
module ixb_access_seq
    import ixb_pkg::*;
#(
    parameter int IADDR_W = 28,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_sel,
    input  logic               host_wr,
    input  hit_e               hit,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic [IADDR_W-1:0] lat_addr,
    input  logic               int_ack,
    input  logic               int_rvalid,
    input  logic [DATA_W-1:0]  int_rdata,
    output logic               ctrl_wen,
    output logic               host_ready,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               int_req,
    output logic               int_we,
    output logic [DATA_W-1:0]  int_wdata
);

    localparam int PAD_W = DATA_W - IADDR_W;

    seq_e              st, nxt;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    assign accept = (st == ST_IDLE) && host_sel;

    always_comb begin
        nxt      = st;
        ctrl_wen = 1'b0;
        case (st)
            ST_IDLE: if (host_sel) begin
                case (hit)
                    HIT_CTRL: begin
                        nxt      = ST_RESP;
                        ctrl_wen = host_wr;
                    end
                    HIT_DATA: nxt = host_wr ? ST_WPUT : ST_RGET;
                    default:  nxt = ST_RESP;
                endcase
            end
            ST_WPUT:  if (int_ack)    nxt = ST_RESP;
            ST_RGET:  if (int_ack)    nxt = ST_RWAIT;
            ST_RWAIT: if (int_rvalid) nxt = ST_RESP;
            ST_RESP:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rdata_q <= '0;
            wdata_q <= '0;
        end else begin
            st <= nxt;
            if (accept) begin
                wdata_q <= host_wdata;
                if (hit == HIT_CTRL && !host_wr) rdata_q <= {{PAD_W{1'b0}}, lat_addr};
                else                             rdata_q <= '0;
            end else if (st == ST_RWAIT && int_rvalid) begin
                rdata_q <= int_rdata;
            end
        end
    end

    assign int_req    = (st == ST_WPUT) || (st == ST_RGET);
    assign int_we     = (st == ST_WPUT);
    assign int_wdata  = wdata_q;
    assign host_ready = (st == ST_RESP);
    assign host_rdata = host_ready ? rdata_q : '0;

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ack) |=> (int_req && $stable(int_we) && $stable(int_wdata)));

    // R4
    read_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_we && int_ack) |=> !host_ready);

endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge
    import ixb_pkg::*;
#(
    parameter int IADDR_W  = 28,
    parameter int DATA_W   = 32,
    parameter int HOST_AW  = 8,
    parameter int CTRL_OFS = 'h00,
    parameter int DATA_OFS = 'h10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_ready,
    output logic               int_req,
    output logic               int_we,
    output logic [IADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0]  int_wdata,
    input  logic               int_ack,
    input  logic               int_rvalid,
    input  logic [DATA_W-1:0]  int_rdata,
    output logic [1:0]         map_sel,
    output logic [1:0]         bank,
    output logic [IADDR_W-5:0] low_field,
    output logic [1:0]         cyc_kind,
    output logic               cyc_vld
);

    localparam logic [HOST_AW-1:0] CTRL_A = HOST_AW'(CTRL_OFS);
    localparam logic [HOST_AW-1:0] DATA_A = HOST_AW'(DATA_OFS);

    hit_e               hit;
    logic               ctrl_wen;
    logic [IADDR_W-1:0] lat_addr;

    assign hit = classify(host_addr == CTRL_A, host_addr == DATA_A);

    ixb_addr_latch #(.IADDR_W(IADDR_W)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .wen  (ctrl_wen),
        .wval (host_wdata[IADDR_W-1:0]),
        .q    (lat_addr)
    );

    ixb_field_split #(.IADDR_W(IADDR_W)) u_split (
        .addr      (lat_addr),
        .map_sel   (map_sel),
        .bank      (bank),
        .low_field (low_field),
        .cyc_kind  (cyc_kind),
        .cyc_vld   (cyc_vld)
    );

    ixb_access_seq #(.IADDR_W(IADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .hit        (hit),
        .host_wdata (host_wdata),
        .lat_addr   (lat_addr),
        .int_ack    (int_ack),
        .int_rvalid (int_rvalid),
        .int_rdata  (int_rdata),
        .ctrl_wen   (ctrl_wen),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .int_req    (int_req),
        .int_we     (int_we),
        .int_wdata  (int_wdata)
    );

    assign int_addr = lat_addr;

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && !int_ack) |=> $stable(int_addr));

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!int_req && !host_ready && int_addr == '0));

    // R9
    cyc_map_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_vld |-> (map_sel == 2'd3 && cyc_kind != 2'd3));

    // R6
    other_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        (host_sel && !host_ready && !int_req && host_addr != CTRL_A && host_addr != DATA_A)
        |=> (!int_req && $stable(int_addr)));

endmodule

// File: tb/ixb_bridge_test.sv
module ixb_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        int_req, int_we;
    logic [27:0] int_addr;
    logic [31:0] int_wdata;
    logic        int_ack = 1'b0;
    logic        int_rvalid = 1'b0;
    logic [31:0] int_rdata = '0;
    logic [1:0]  map_sel, bank, cyc_kind;
    logic [23:0] low_field;
    logic        cyc_vld;

    int tests = 0;
    int fails = 0;

    // responder state
    int          ack_cnt = 0;
    int          rd_cnt = 0;
    int          rd_dly = 0;
    bit          rpend = 0;
    int          nreq = 0;
    logic [27:0] last_addr;
    logic        last_we;
    logic [31:0] last_wdata;
    logic [27:0] hold_addr;
    bit          hold_seen = 0;
    int          hold_bad = 0;

    // host task results
    logic [31:0] got;
    int          lat;
    int          after_ready;

    always #5 clk = ~clk;

    ixb_bridge uut (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .int_ack(int_ack), .int_rvalid(int_rvalid), .int_rdata(int_rdata),
        .map_sel(map_sel), .bank(bank), .low_field(low_field),
        .cyc_kind(cyc_kind), .cyc_vld(cyc_vld)
    );

    function automatic logic [31:0] mem_val(input logic [27:0] a);
        return {4'hC, a} ^ 32'h1357_9BDF;
    endfunction

    // internal-port responder, acting on falling edges
    always @(negedge clk) begin
        if (int_rvalid) int_rvalid = 1'b0;
        else if (rpend && !int_ack) begin
            if (rd_cnt == 0) begin
                int_rvalid = 1'b1;
                int_rdata  = mem_val(last_addr);
                rpend      = 0;
            end else rd_cnt--;
        end
        if (int_ack) begin
            int_ack   = 1'b0;
            hold_seen = 0;
        end else if (int_req) begin
            if (hold_seen && int_addr != hold_addr) hold_bad++;
            hold_addr = int_addr;
            hold_seen = 1;
            if (ack_cnt == 0) begin
                int_ack    = 1'b1;
                nreq++;
                last_addr  = int_addr;
                last_we    = int_we;
                last_wdata = int_wdata;
                if (!int_we) begin
                    rpend  = 1;
                    rd_cnt = rd_dly;
                end
            end else ack_cnt--;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic host_op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                           input int ad, input int rdl);
        int n = 0;
        ack_cnt = ad;
        rd_dly  = rdl;
        @(negedge clk);
        host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ready && n < 100);
        got = host_rdata;
        lat = n;
        host_sel = 1'b0;
        @(negedge clk);
        after_ready = int'(host_ready);
    endtask

    task automatic t_reset();
        check(host_ready == 1'b0, "R10 ready", 32'(host_ready), 0);
        check(int_req == 1'b0, "R10 req", 32'(int_req), 0);
        check(int_addr == 28'h0, "R10 addr", 32'(int_addr), 0);
        host_op(0, 8'h00, 0, 0, 0);
        check(got == 0, "R10 ctrl read", got, 0);
    endtask

    task automatic t_ctrl();
        host_op(1, 8'h00, 32'hFABC_DEF1, 0, 0);
        check(lat == 1, "R1 write latency", lat, 1);
        check(after_ready == 0, "R11 pulse", after_ready, 0);
        host_op(0, 8'h00, 0, 0, 0);
        check(got == 32'h0ABC_DEF1, "R1 read back", got, 32'h0ABC_DEF1);
        check(lat == 1, "R1 read latency", lat, 1);
        check(map_sel == 2'd2, "R7 map", 32'(map_sel), 2);
        check(bank == 2'd2, "R8 bank", 32'(bank), 2);
        check(low_field == 24'hBCDEF1, "R9 low", 32'(low_field), 32'hBCDEF1);
        check(cyc_vld == 1'b0, "R9 no cycle", 32'(cyc_vld), 0);
    endtask

    task automatic t_fields();
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 4; b++) begin
                host_op(1, 8'h00, {4'h0, 2'(m), 2'(b), 24'h00A5C2}, 0, 0);
                check(map_sel == 2'(m), "R7 map sweep", 32'(map_sel), 32'(m));
                check(bank == 2'(b), "R8 bank sweep", 32'(bank), 32'(b));
                check(cyc_vld == (m == 3), "R9 vld sweep", 32'(cyc_vld), 32'(m == 3));
            end
        end
        for (int k = 0; k < 4; k++) begin
            host_op(1, 8'h00, {4'h0, 2'd3, 2'd1, 22'h0, 2'(k)}, 0, 0);
            check(cyc_vld == (k != 3), "R9 kind vld", 32'(cyc_vld), 32'(k != 3));
            check(cyc_kind == 2'(k), "R9 kind", 32'(cyc_kind), 32'(k));
        end
    endtask

    task automatic t_wr(input int ad);
        int n0;
        host_op(1, 8'h00, 32'h0123_4567, 0, 0);
        n0 = nreq;
        host_op(1, 8'h10, 32'hDEAD_0000 + 32'(ad), ad, 0);
        check(nreq == n0 + 1, "R3 one request", nreq, n0 + 1);
        check(last_we == 1'b1, "R3 we", 32'(last_we), 1);
        check(last_addr == 28'h123_4567, "R3 addr", 32'(last_addr), 32'h0123_4567);
        check(last_wdata == 32'hDEAD_0000 + 32'(ad), "R3 data", last_wdata, 32'hDEAD_0000 + 32'(ad));
        check(lat == 2 + ad, "R3 latency", lat, 2 + ad);
        check(hold_bad == 0, "R5 hold", hold_bad, 0);
    endtask

    task automatic t_rd(input int ad, input int rdl);
        int n0;
        host_op(1, 8'h00, 32'h0B21_0040 + 32'(rdl), 0, 0);
        n0 = nreq;
        host_op(0, 8'h10, 0, ad, rdl);
        check(nreq == n0 + 1, "R4 one request", nreq, n0 + 1);
        check(last_we == 1'b0, "R4 we", 32'(last_we), 0);
        check(got == mem_val(28'hB21_0040 + 28'(rdl)), "R4 data", got, mem_val(28'hB21_0040 + 28'(rdl)));
        check(lat == 4 + ad + rdl, "R4 stall", lat, 4 + ad + rdl);
        check(after_ready == 0, "R11 pulse read", after_ready, 0);
    endtask

    task automatic t_persist();
        host_op(1, 8'h00, 32'h0765_4321, 0, 0);
        host_op(1, 8'h10, 32'h1111_2222, 1, 0);
        host_op(0, 8'h10, 0, 0, 1);
        host_op(0, 8'h10, 0, 2, 0);
        check(last_addr == 28'h765_4321, "R2 addr used", 32'(last_addr), 32'h0765_4321);
        host_op(0, 8'h00, 0, 0, 0);
        check(got == 32'h0765_4321, "R2 persists", got, 32'h0765_4321);
    endtask

    task automatic t_other();
        int n0;
        host_op(1, 8'h00, 32'h0246_8ACE, 0, 0);
        n0 = nreq;
        host_op(1, 8'h04, 32'hFFFF_FFFF, 0, 0);
        check(lat == 1, "R6 write latency", lat, 1);
        host_op(1, 8'h20, 32'h0000_0001, 0, 0);
        host_op(0, 8'h14, 0, 0, 0);
        check(got == 0, "R6 read zero", got, 0);
        check(lat == 1, "R6 read latency", lat, 1);
        check(nreq == n0, "R6 no request", nreq, n0);
        host_op(0, 8'h00, 0, 0, 0);
        check(got == 32'h0246_8ACE, "R6 latch unchanged", got, 32'h0246_8ACE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_fields();
        t_wr(0);
        t_wr(3);
        t_rd(0, 0);
        t_rd(2, 3);
        t_persist();
        t_other();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule